// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block is the digital gate-control core of a fixed-frequency synchronous step-down controller. It runs on a fast system clock. A one-clock cycle pulse marks the start of each switching period, and a one-clock trip from the PWM comparator ends the on-time. A soft-start-done flag and a fault flag arrive as synchronous inputs. From these it drives a high-side gate enable and a low-side gate enable. A programmable dead time, counted in system clocks, separates the two gates on each transition. Ramp generation, error amplification and analog comparison sit outside the block.

Three behaviours are added around the basic trailing-edge latch. A minimum on-time keeps a trip that comes too early from producing a runt pulse. A full-duty watchdog counts consecutive switching periods in which the latch never cleared. When the limit is reached, it clears the latch halfway through the next period, so the low-side switch conducts for the rest of that period and the bootstrap capacitor is recharged. A startup lockout holds the low-side switch off after reset or after any fault. The lockout lifts only when the high side has been commanded on once, or when soft start reports completion.

The minimum on-time policy is chosen by parameter. Stretch mode, the default, remembers an early trip and applies it when the minimum width expires. Suppress mode drops an early trip.

Top module: `buck_gate_seq`

## Requirements
- R1: After reset both gate outputs are low. They stay low while no cycle pulse and no soft-start-done flag arrive.
- R2: `gate_hi` and `gate_lo` are never high in the same cycle.
- R3: While `fault` is high, both gate outputs are low in that same cycle. A fault also clears the PWM latch and re-arms the startup lockout.
- R4: A cycle pulse sets the PWM latch and a trip clears it. When a trip and a cycle pulse coincide on a clear latch, the latch stays clear (reset wins). With the low side already off, `gate_hi` is high for exactly as many clocks as the latch is set.
- R5: `gate_lo` cannot rise until the latch has been set at least once, or until `ss_done` has been seen high, counted since reset or since the last fault.
- R6: `gate_hi` rises only after `gate_lo` has been low for DT_LO_HI clocks (default 5). `gate_lo` rises only after `gate_hi` has been low for DT_HI_LO clocks (default 2). Each rises at the first clock this allows. With the low side on when the latch sets and a trip at clock offset T, `gate_hi` is high for T-DT_LO_HI clocks.
- R7: Once set, the latch stays set for at least MIN_ON clocks (default 9). In the default stretch mode, a trip that arrives earlier ends the pulse exactly when MIN_ON is reached.
- R8: When the latch has stayed set through FULL_LIMIT consecutive periods (default 20), it is cleared on the clock where the phase counter reaches PERIOD_CNT/2 in the next period. The phase counter is 0 on the clock after the cycle pulse.
- R9: After that forced clear, `gate_lo` turns on after the dead time and remains on until the next cycle pulse.
- R10: Any period in which the latch is clear at some clock restarts the full-duty count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_pulse | input | 1 | One-clock marker at the start of each switching period |
| pwm_trip | input | 1 | PWM comparator trip, ends the on-time |
| ss_done | input | 1 | Soft-start level has passed its threshold |
| fault | input | 1 | Any protection fault active |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
Two functions can act on the latch in the same clock: the full-duty forced clear and the cycle pulse, and separately a comparator trip and the cycle pulse. The bench places a trip exactly on the cycle pulse to confirm that reset wins. It then runs more than twenty untripped periods and measures how many clocks each gate is high in the forced period. A trip placed early in a period checks that the counter restarts. Every clock, the gate outputs are compared with a behavioural reference model that recomputes latch, counter and dead-time state from the inputs alone.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
   typedef enum logic {
      MINON_STRETCH  = 1'b0,
      MINON_SUPPRESS = 1'b1
   } minon_mode_e;
endpackage

// File: rtl/bgs_pwm_latch.sv
module bgs_pwm_latch
   import bgs_pkg::*;
#(
   parameter int unsigned MIN_ON = 9,
   parameter minon_mode_e MODE   = MINON_STRETCH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_pulse,
   input  logic trip,
   input  logic force_rst,
   input  logic fault,
   output logic q,
   output logic q_nxt
);
   localparam int unsigned ON_W = $clog2(MIN_ON + 1);
   localparam logic [ON_W-1:0] ON_LAST = ON_W'(MIN_ON - 1);

   logic [ON_W-1:0] on_len;
   logic            pend_q, pend_d;
   logic            masked, trip_eff, rst_req;

   assign masked = q && (on_len < ON_LAST);

   generate
      if (MODE == MINON_STRETCH) begin : g_stretch
         assign trip_eff = trip | pend_q;
         assign pend_d   = ~fault & masked & trip_eff;
      end else begin : g_suppress
         assign trip_eff = trip;
         assign pend_d   = 1'b0;
      end
   endgenerate

   // clear has priority over set
   assign rst_req = fault | force_rst | (trip_eff & ~masked);
   assign q_nxt   = rst_req ? 1'b0 : (cyc_pulse | q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= 1'b0;
         pend_q <= 1'b0;
         on_len <= '0;
      end else begin
         q      <= q_nxt;
         pend_q <= pend_d;
         if (q && q_nxt)
            on_len <= (on_len == ON_LAST) ? on_len : on_len + 1'b1;
         else
            on_len <= '0;
      end
   end

   assert_reset_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_pulse && trip && !q) |=> !q);

   assert_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(q) && !$past(fault) && !$past(force_rst)) |-> ($past(on_len) == ON_LAST));

   assert_forced_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      force_rst |=> !q);
endmodule

// File: rtl/bgs_full_duty.sv
module bgs_full_duty #(
   parameter int unsigned PERIOD_CNT = 77,
   parameter int unsigned FULL_LIMIT = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_pulse,
   input  logic fault,
   input  logic q,
   input  logic q_nxt,
   output logic force_rst
);
   localparam int unsigned PH_W  = $clog2(PERIOD_CNT);
   localparam int unsigned CNT_W = $clog2(FULL_LIMIT + 1);
   localparam logic [PH_W-1:0]  PH_HALF = PH_W'(PERIOD_CNT / 2);
   localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(PERIOD_CNT - 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FULL_LIMIT);

   logic [PH_W-1:0]  phase;
   logic [CNT_W-1:0] full_cnt;
   logic             fell;

   assign force_rst = q && (full_cnt == CNT_TOP) && (phase == PH_HALF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         full_cnt <= '0;
         fell     <= 1'b1;
      end else begin
         if (cyc_pulse) begin
            phase <= '0;
            fell  <= ~q_nxt;
         end else begin
            phase <= (phase == PH_TOP) ? phase : phase + 1'b1;
            fell  <= fell | ~q_nxt;
         end
         if (fault)
            full_cnt <= '0;
         else if (cyc_pulse) begin
            if (!fell && q && q_nxt)
               full_cnt <= (full_cnt == CNT_TOP) ? full_cnt : full_cnt + 1'b1;
            else
               full_cnt <= '0;
         end
      end
   end

   assert_count_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_pulse && !q) |=> (full_cnt == '0));
endmodule

// File: rtl/bgs_dead_time.sv
module bgs_dead_time #(
   parameter int unsigned GAP = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic other,
   output logic gate
);
   localparam int unsigned W = $clog2(GAP + 1);
   localparam logic [W-1:0] SAT  = W'(GAP);
   localparam logic [W-1:0] NEED = W'(GAP - 1);

   logic [W-1:0] off_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_cnt <= '0;
         gate    <= 1'b0;
      end else begin
         off_cnt <= other ? '0 : ((off_cnt == SAT) ? off_cnt : off_cnt + 1'b1);
         gate    <= req && !other && (off_cnt >= NEED);
      end
   end

   assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> !$past(other));

   assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !gate);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
   import bgs_pkg::*;
#(
   parameter int unsigned PERIOD_CNT  = 77,
   parameter int unsigned DT_LO_HI    = 5,
   parameter int unsigned DT_HI_LO    = 2,
   parameter int unsigned MIN_ON      = 9,
   parameter int unsigned FULL_LIMIT  = 20,
   parameter minon_mode_e MIN_ON_MODE = MINON_STRETCH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_pulse,
   input  logic pwm_trip,
   input  logic ss_done,
   input  logic fault,
   output logic gate_hi,
   output logic gate_lo
);
   generate
      if (DT_LO_HI < 1 || DT_HI_LO < 1) begin : g_bad_gap
         $error("dead time must be at least one clock");
      end
      if (MIN_ON < 2) begin : g_bad_min
         $error("minimum on-time must be at least two clocks");
      end
      if (PERIOD_CNT / 2 <= MIN_ON + DT_LO_HI) begin : g_bad_period
         $error("period too short for minimum on-time and dead time");
      end
      if (FULL_LIMIT < 1) begin : g_bad_limit
         $error("full-duty limit must be at least one");
      end
   endgenerate

   logic q, q_nxt, force_rst;
   logic armed;
   logic hi_r, lo_r;
   logic req_hi, req_lo;

   bgs_pwm_latch #(.MIN_ON(MIN_ON), .MODE(MIN_ON_MODE)) u_latch (
      .clk(clk), .rst_n(rst_n), .cyc_pulse(cyc_pulse), .trip(pwm_trip),
      .force_rst(force_rst), .fault(fault), .q(q), .q_nxt(q_nxt)
   );

   bgs_full_duty #(.PERIOD_CNT(PERIOD_CNT), .FULL_LIMIT(FULL_LIMIT)) u_full (
      .clk(clk), .rst_n(rst_n), .cyc_pulse(cyc_pulse), .fault(fault),
      .q(q), .q_nxt(q_nxt), .force_rst(force_rst)
   );

   // lockout: low side held off until a high-side attempt or soft start done
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= ~fault & (armed | q | ss_done);
   end

   assign req_hi = q & ~fault;
   assign req_lo = ~q & armed & ~fault;

   bgs_dead_time #(.GAP(DT_LO_HI)) u_dt_hi (
      .clk(clk), .rst_n(rst_n), .req(req_hi), .other(lo_r), .gate(hi_r)
   );

   bgs_dead_time #(.GAP(DT_HI_LO)) u_dt_lo (
      .clk(clk), .rst_n(rst_n), .req(req_lo), .other(hi_r), .gate(lo_r)
   );

   assign gate_hi = hi_r & ~fault;
   assign gate_lo = lo_r & ~fault;

   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   assert_fault_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!gate_hi && !gate_lo));

   assert_fault_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !armed);

   assert_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lo |-> armed);
endmodule

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;
   localparam int PERIOD   = 77;
   localparam int DT_LH    = 5;
   localparam int DT_HL    = 2;
   localparam int MIN_ON   = 9;
   localparam int LIMIT    = 20;
   localparam int HALF     = PERIOD / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_pulse = 1'b0, pwm_trip = 1'b0, ss_done = 1'b0, fault = 1'b0;
   logic gate_hi, gate_lo;

   int n_checks = 0, n_fails = 0;
   int hi_cnt = 0, lo_cnt = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   buck_gate_seq #(.PERIOD_CNT(PERIOD), .DT_LO_HI(DT_LH), .DT_HI_LO(DT_HL),
                   .MIN_ON(MIN_ON), .FULL_LIMIT(LIMIT)) i_buck_gate_seq (
      .clk(clk), .rst_n(rst_n), .cyc_pulse(cyc_pulse), .pwm_trip(pwm_trip),
      .ss_done(ss_done), .fault(fault), .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   // behavioural reference model
   int  m_on, m_cnt, m_phase, m_hoff, m_loff;
   bit  m_q, m_pend, m_fell, m_arm, m_hi, m_lo;
   bit  t_mask, t_force, t_trip, t_rst, t_q;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q = 0; m_pend = 0; m_on = 0; m_cnt = 0; m_fell = 1; m_phase = 0;
         m_arm = 0; m_hi = 0; m_lo = 0; m_hoff = 0; m_loff = 0;
      end else begin
         t_mask  = m_q && (m_on < MIN_ON - 1);
         t_force = m_q && (m_cnt == LIMIT) && (m_phase == HALF);
         t_trip  = pwm_trip || m_pend;
         t_rst   = fault || t_force || (t_trip && !t_mask);
         t_q     = t_rst ? 1'b0 : (cyc_pulse || m_q);
         if (fault) m_cnt = 0;
         else if (cyc_pulse) m_cnt = (!m_fell && m_q && t_q) ? ((m_cnt < LIMIT) ? m_cnt + 1 : m_cnt) : 0;
         if (cyc_pulse) begin m_phase = 0; m_fell = !t_q; end
         else begin
            if (m_phase < PERIOD - 1) m_phase++;
            m_fell = m_fell || !t_q;
         end
         m_pend = !fault && t_mask && t_trip;
         m_on   = (m_q && t_q) ? ((m_on < MIN_ON - 1) ? m_on + 1 : m_on) : 0;
         begin
            bit nh, nl;
            nh = m_q && !fault && !m_lo && (m_loff >= DT_LH - 1);
            nl = !m_q && m_arm && !fault && !m_hi && (m_hoff >= DT_HL - 1);
            m_loff = m_lo ? 0 : ((m_loff < DT_LH) ? m_loff + 1 : m_loff);
            m_hoff = m_hi ? 0 : ((m_hoff < DT_HL) ? m_hoff + 1 : m_hoff);
            m_arm  = !fault && (m_arm || m_q || ss_done);
            m_hi = nh; m_lo = nl;
         end
         m_q = t_q;
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic c, input logic t);
      @(negedge clk);
      check(gate_hi === (m_hi && !fault), cur_req, "gate_hi vs model", int'(gate_hi), int'(m_hi && !fault));
      check(gate_lo === (m_lo && !fault), cur_req, "gate_lo vs model", int'(gate_lo), int'(m_lo && !fault));
      if (gate_hi) hi_cnt++;
      if (gate_lo) lo_cnt++;
      cyc_pulse = c;
      pwm_trip  = t;
   endtask

   task automatic period(input int trip_at);
      hi_cnt = 0; lo_cnt = 0;
      for (int k = 0; k < PERIOD; k++) step(k == 0, k == trip_at);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(gate_hi == 0 && gate_lo == 0, "R1", "gates in reset", int'({gate_hi, gate_lo}), 0);
      rst_n = 1'b1;
      // R1: idle after reset
      cur_req = "R1";
      hi_cnt = 0; lo_cnt = 0;
      for (int i = 0; i < 20; i++) step(0, 0);
      check(hi_cnt == 0 && lo_cnt == 0, "R1", "idle gate activity", hi_cnt + lo_cnt, 0);

      // R4: trip on the cycle pulse keeps the latch clear; R5 lockout holds low side off
      cur_req = "R4";
      for (int i = 0; i < 2; i++) begin
         period(0);
         check(hi_cnt == 0, "R4", "hi clocks, trip on pulse", hi_cnt, 0);
         check(lo_cnt == 0, "R5", "lo clocks before any attempt", lo_cnt, 0);
      end

      // R4/R6: normal modulation
      cur_req = "R6";
      period(30);
      check(hi_cnt == 30, "R4", "hi clocks, first pulse", hi_cnt, 30);
      period(30);
      check(hi_cnt == 30 - DT_LH, "R6", "hi clocks after lo dead time", hi_cnt, 30 - DT_LH);
      check(lo_cnt > 0, "R5", "lo active after attempt", lo_cnt, 1);
      period(45);
      check(hi_cnt == 45 - DT_LH, "R6", "hi clocks, trip 45", hi_cnt, 45 - DT_LH);

      // R7: early trip stretched to minimum width
      cur_req = "R7";
      period(3);
      check(hi_cnt == MIN_ON - DT_LH, "R7", "hi clocks, early trip", hi_cnt, MIN_ON - DT_LH);
      period(30);

      // R10: ten untripped periods then a trip restarts the count
      cur_req = "R10";
      for (int i = 0; i < 10; i++) period(-1);
      period(50);
      cur_req = "R8";
      for (int j = 1; j <= 23; j++) begin
         period(-1);
         if (j >= 2 && j <= LIMIT)
            check(lo_cnt == 0, "R10", "lo clocks in full-duty run", lo_cnt, 0);
         if (j == LIMIT + 1) begin
            check(hi_cnt == HALF + 3, "R8", "hi clocks in forced period", hi_cnt, HALF + 3);
            check(lo_cnt == PERIOD - HALF - 3 - DT_HL, "R9", "lo clocks after forced clear",
                  lo_cnt, PERIOD - HALF - 3 - DT_HL);
         end
      end

      // R3: fault mid-period
      cur_req = "R3";
      hi_cnt = 0; lo_cnt = 0;
      for (int k = 0; k < 20; k++) step(k == 0, 0);
      fault = 1'b1;
      for (int k = 0; k < 5; k++) begin
         step(0, 0);
         check(gate_hi == 0 && gate_lo == 0, "R3", "gates during fault", int'({gate_hi, gate_lo}), 0);
      end
      @(negedge clk); fault = 1'b0;
      cur_req = "R5";
      lo_cnt = 0; hi_cnt = 0;
      for (int k = 0; k < 20; k++) step(0, 0);
      check(lo_cnt == 0 && hi_cnt == 0, "R3", "lockout re-armed after fault", lo_cnt + hi_cnt, 0);
      ss_done = 1'b1;
      for (int k = 0; k < 10; k++) step(0, 0);
      check(gate_lo == 1, "R5", "lo released by soft start done", int'(gate_lo), 1);
      period(20);
      check(hi_cnt == 20 - DT_LH, "R6", "hi clocks after release", hi_cnt, 20 - DT_LH);

      done = 1'b1;
      finish_run();
   end
endmodule